// File: doc/BRIEF.md
# Global-History Direction Predictor with Update-Time Inversion Hints

This block predicts the direction of conditional branches from global history alone. A history register indexes a table of two-bit saturating counters, and the top bit of the selected counter is the prediction. No instruction bits feed the prediction path, so the response is available in the same cycle as the request. Each response also returns the history value that produced it. That value serves as a checkpoint for later repair.

On the history write path, each branch carries a one-bit inversion hint. The bit shifted into history is the direction XOR the hint. Branches that would otherwise produce the same history can then be steered to different counters. History is advanced speculatively with the predicted direction. When a branch resolves, its counter is trained at the index given by its checkpoint. On a misprediction, history is rebuilt from that checkpoint with the corrected bit.

Top module: `gag_inv_predictor`

## Requirements
- R1: After reset the history is zero and every counter holds weakly not-taken (encoding 01). The first response is therefore not-taken with checkpoint zero.
- R2: The prediction is the most significant bit of the counter selected by the history alone. Counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. The prediction and the checkpoint (the current history) are valid in the same cycle as the request.
- R3: The prediction and the checkpoint do not depend on `pred_hint_i`.
- R4: A predict request without a same-cycle repair shifts the history left by one on the next edge. The new least significant bit is the predicted direction XOR `pred_hint_i`.
- R5: With no predict request and no repair, the history holds its value.
- R6: A resolve trains the counter at index `res_ckpt_i`, not at the current history. Taken increments the counter up to a limit of 11, and not-taken decrements it down to a limit of 00.
- R7: A resolve flagged as mispredicted loads the history with `res_ckpt_i` shifted left by one, with `res_taken_i` XOR `res_hint_i` as the new least significant bit.
- R8: A resolve that is not flagged as mispredicted leaves the history path alone: the history holds, or shifts under R4 if a request is present.
- R9: When a predict request and a mispredicted resolve arrive in the same cycle, the repair sets the next history. The request still gets its response from the history and counters before the edge.
- R10: When the resolve trains the counter that is being read, the response in that cycle shows the old counter value. The new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_req_i | input | 1 | Predict request; advances history speculatively |
| pred_hint_i | input | 1 | Inversion hint of the predicted branch, used only for the history shift |
| pred_taken_o | output | 1 | Predicted direction |
| pred_ckpt_o | output | HIST_W | History checkpoint that produced the prediction |
| res_valid_i | input | 1 | Resolved branch present |
| res_taken_i | input | 1 | Actual direction |
| res_hint_i | input | 1 | Inversion hint of the resolved branch |
| res_mispred_i | input | 1 | Resolved branch was mispredicted; repair history |
| res_ckpt_i | input | HIST_W | Checkpoint returned with the prediction of this branch |

## Verification
The prediction and the checkpoint are combinational outputs of state, so each is due in the cycle its inputs are applied. History shifts, repairs and counter training first become visible one edge later. Inputs are driven on the falling edge, and the outputs are sampled one nanosecond after that. These same-cycle samples cover R2, R3, R9 and R10. A second sample is taken one nanosecond after the following rising edge, which covers the state effects. Expected values come from a small model of the history and the counter array kept in the bench.

// File: rtl/ghp_pkg.sv
package ghp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    logic [1:0] v;
    v = c;
    if (up) begin
      if (c != CTR_ST) v = v + 2'd1;
    end else begin
      if (c != CTR_SNT) v = v - 2'd1;
    end
    return ctr_t'(v);
  endfunction
endpackage

// File: rtl/ghp_table.sv
module ghp_table
  import ghp_pkg::*;
#(
  parameter int HIST_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIST_W-1:0] rd_idx_i,
  output ctr_t              rd_ctr_o,
  input  logic              wr_en_i,
  input  logic [HIST_W-1:0] wr_idx_i,
  input  logic              wr_taken_i
);
  localparam int ENTRIES = 1 << HIST_W;

  ctr_t mem [ENTRIES];
  ctr_t wr_old;

  assign wr_old   = mem[wr_idx_i];
  assign rd_ctr_o = mem[rd_idx_i];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem[i] <= CTR_WNT;
      else if (wr_en_i && wr_idx_i == HIST_W'(i))   mem[i] <= ctr_step(mem[i], wr_taken_i);
    end
  end

  // trained counter moves toward the outcome unless already at that end
  assert_sat_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mem[$past(wr_idx_i)] != $past(wr_old)) ||
                ($past(wr_old) == ($past(wr_taken_i) ? CTR_ST : CTR_SNT)));

  // never jumps across more than one state
  assert_no_jump_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !((mem[$past(wr_idx_i)] == CTR_ST  && $past(wr_old) == CTR_SNT) ||
                  (mem[$past(wr_idx_i)] == CTR_SNT && $past(wr_old) == CTR_ST)));
endmodule

// File: rtl/ghp_history.sv
module ghp_history #(
  parameter int HIST_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spec_en_i,
  input  logic              spec_bit_i,
  input  logic              rep_en_i,
  input  logic [HIST_W-2:0] rep_base_i,
  input  logic              rep_bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q <= '0;
    else if (rep_en_i)  hist_q <= {rep_base_i, rep_bit_i};
    else if (spec_en_i) hist_q <= {hist_q[HIST_W-2:0], spec_bit_i};
  end

  assign hist_o = hist_q;

  assert_repair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_en_i |=> hist_o == {$past(rep_base_i), $past(rep_bit_i)});

  assert_spec_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_en_i && !rep_en_i) |=> hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0]));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spec_en_i && !rep_en_i) |=> $stable(hist_o));
endmodule

// File: rtl/gag_inv_predictor.sv
module gag_inv_predictor
  import ghp_pkg::*;
#(
  parameter int HIST_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_req_i,
  input  logic              pred_hint_i,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_ckpt_o,
  input  logic              res_valid_i,
  input  logic              res_taken_i,
  input  logic              res_hint_i,
  input  logic              res_mispred_i,
  input  logic [HIST_W-1:0] res_ckpt_i
);
  logic [HIST_W-1:0] hist;
  ctr_t              rd_ctr;
  logic              repair;

  assign repair = res_valid_i && res_mispred_i;

  ghp_history #(.HIST_W(HIST_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .spec_en_i  (pred_req_i),
    .spec_bit_i (rd_ctr[1] ^ pred_hint_i),
    .rep_en_i   (repair),
    .rep_base_i (res_ckpt_i[HIST_W-2:0]),
    .rep_bit_i  (res_taken_i ^ res_hint_i),
    .hist_o     (hist)
  );

  // index comes from the resolving branch's checkpoint, not live history
  ghp_table #(.HIST_W(HIST_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (hist),
    .rd_ctr_o   (rd_ctr),
    .wr_en_i    (res_valid_i),
    .wr_idx_i   (res_ckpt_i),
    .wr_taken_i (res_taken_i)
  );

  assign pred_taken_o = rd_ctr[1];
  assign pred_ckpt_o  = hist;

  // taken training of the entry being read keeps a taken prediction taken
  assert_rdwr_taken_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_mispred_i && !pred_req_i && res_taken_i &&
     res_ckpt_i == pred_ckpt_o && pred_taken_o) |=> pred_taken_o);

  // non-repair resolve alone never changes history
  assert_no_repair_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_mispred_i && !pred_req_i) |=> $stable(pred_ckpt_o));
endmodule

// File: tb/gag_inv_predictor_tb.sv
module gag_inv_predictor_tb;
  localparam int W = 11;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pred_req = 1'b0, pred_hint = 1'b0;
  logic         res_valid = 1'b0, res_taken = 1'b0, res_hint = 1'b0, res_mispred = 1'b0;
  logic [W-1:0] res_ckpt = '0;
  logic         pred_taken;
  logic [W-1:0] pred_ckpt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int           m_ctr [N];
  logic [W-1:0] m_hist;

  always #4 clk = ~clk;

  gag_inv_predictor #(.HIST_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_req_i(pred_req), .pred_hint_i(pred_hint),
    .pred_taken_o(pred_taken), .pred_ckpt_o(pred_ckpt),
    .res_valid_i(res_valid), .res_taken_i(res_taken), .res_hint_i(res_hint),
    .res_mispred_i(res_mispred), .res_ckpt_i(res_ckpt)
  );

  task automatic check_out(input string tag);
    logic exp_p;
    exp_p = (m_ctr[m_hist] >= 2);
    checks++;
    if (pred_taken !== exp_p || pred_ckpt !== m_hist) begin
      errors++;
      $display("FAIL %s: taken=%0b ckpt=%0d expected taken=%0b ckpt=%0d",
               tag, pred_taken, pred_ckpt, exp_p, m_hist);
    end
  endtask

  task automatic step(input logic pv, input logic ph, input logic rv, input logic rt,
                      input logic rh, input logic rm, input logic [W-1:0] rc,
                      input string tag);
    logic         old_p;
    logic [W-1:0] nh;
    @(negedge clk);
    pred_req = pv; pred_hint = ph;
    res_valid = rv; res_taken = rt; res_hint = rh; res_mispred = rm; res_ckpt = rc;
    #1;
    check_out({tag, " same-cycle"});
    old_p = (m_ctr[m_hist] >= 2);
    nh = m_hist;
    if (rv && rm)  nh = {rc[W-2:0], rt ^ rh};
    else if (pv)   nh = {m_hist[W-2:0], old_p ^ ph};
    if (rv) begin
      if (rt && m_ctr[rc] < 3)       m_ctr[rc] = m_ctr[rc] + 1;
      else if (!rt && m_ctr[rc] > 0) m_ctr[rc] = m_ctr[rc] - 1;
    end
    @(posedge clk);
    #1;
    pred_req = 0; pred_hint = 0; res_valid = 0; res_taken = 0;
    res_hint = 0; res_mispred = 0; res_ckpt = '0;
    m_hist = nh;
    check_out({tag, " after edge"});
  endtask

  // repair through a sacrificial entry with the top index bit set
  task automatic set_hist(input logic [W-1:0] v, input string tag);
    step(0, 0, 1, v[0], 0, 1, {1'b1, v[W-1:1]}, tag);
  endtask

  task automatic t_reset;
    check_out("R1 reset state");
    step(0, 0, 0, 0, 0, 0, '0, "R5 idle hold");
  endtask

  task automatic t_spec;
    step(1, 0, 0, 0, 0, 0, '0, "R4 shift hint0");
    step(1, 1, 0, 0, 0, 0, '0, "R4 shift hint1");
    step(1, 1, 0, 0, 0, 0, '0, "R4 shift hint1 again");
    step(1, 0, 0, 0, 0, 0, '0, "R2 R4 shift");
    step(0, 0, 0, 0, 0, 0, '0, "R5 hold");
  endtask

  task automatic t_hint_indep;
    logic p0, p1;
    logic [W-1:0] c0, c1;
    @(negedge clk);
    pred_req = 1; pred_hint = 0; #1; p0 = pred_taken; c0 = pred_ckpt;
    pred_hint = 1; #1; p1 = pred_taken; c1 = pred_ckpt;
    pred_req = 0; pred_hint = 0;
    checks++;
    if (p0 !== p1 || c0 !== c1) begin
      errors++;
      $display("FAIL R3 hint changed response: taken=%0b ckpt=%0d expected taken=%0b ckpt=%0d",
               p1, c1, p0, c0);
    end
    check_out("R3 response vs model");
  endtask

  task automatic t_sat;
    set_hist(11'd5, "R7 set history 5");
    step(0, 0, 1, 1, 0, 0, 11'd5, "R6 inc 01->10");
    step(0, 0, 1, 1, 0, 0, 11'd5, "R6 inc 10->11");
    step(0, 0, 1, 1, 0, 0, 11'd5, "R6 sat at 11");
    step(0, 0, 1, 0, 0, 0, 11'd5, "R6 dec 11->10");
    step(0, 0, 1, 0, 0, 0, 11'd5, "R6 dec 10->01");
    step(0, 0, 1, 0, 0, 0, 11'd5, "R6 dec 01->00");
    step(0, 0, 1, 0, 0, 0, 11'd5, "R6 sat at 00");
    step(0, 0, 1, 1, 0, 0, 11'd5, "R6 inc 00->01");
    step(0, 0, 1, 1, 0, 0, 11'd5, "R6 inc 01->10");
  endtask

  task automatic t_ckpt_index;
    step(0, 0, 1, 1, 0, 0, 11'd9, "R6 R8 train other index");
    step(0, 0, 1, 1, 0, 0, 11'd9, "R6 train other index again");
    set_hist(11'd9, "R6 read trained index 9");
  endtask

  task automatic t_repair;
    step(1, 0, 0, 0, 0, 0, '0, "R4 spec before repair");
    step(0, 0, 1, 1, 1, 1, 11'd9, "R7 repair taken hint1");
    step(0, 0, 1, 0, 1, 1, 11'd18, "R7 repair nottaken hint1");
    step(1, 1, 1, 1, 0, 0, 11'd3, "R8 resolve no repair with shift");
  endtask

  task automatic t_collide;
    set_hist(11'd9, "R9 setup");
    step(1, 1, 1, 0, 0, 1, 11'd40, "R9 repair beats spec");
    step(1, 0, 1, 1, 1, 1, 11'd81, "R9 repair beats spec 2");
  endtask

  task automatic t_rdwr;
    set_hist(11'd12, "R10 setup");
    step(0, 0, 1, 1, 0, 0, 11'd12, "R10 old value then new");
    step(0, 0, 1, 0, 0, 0, 11'd12, "R10 taken to not taken");
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_ctr[i] = 1;
    m_hist = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_spec();
    t_hint_indep();
    t_sat();
    t_ckpt_index();
    t_repair();
    t_collide();
    t_rdwr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule